// File: doc/BRIEF.md
# Clock gear and source switch controller

This block derives the chip's system state clock from two oscillator sources: a fast clock, which is the block's own `clk`, and a slow clock, which reaches the block as a one-cycle pulse `fs_tick` in the `clk` domain. The fast path passes through a gear divider that divides by 1, 2, 4, 8 or 16. A source mux then picks either the geared fast clock or the slow clock. A final divide-by-two turns the chosen clock into the system clock. That clock leaves the block as the clock-enable pulse train `sys_tick`, and one `sys_tick` period is one state. The two oscillator enables are modelled as gates on these pulses and are brought out as outputs.

Software drives the block through a small write port with three registers. `OSC` (address 0) holds the fast enable in bit 0 and the slow enable in bit 1; writing 1 to bit 2 starts the warm-up counter. `CLK` (address 1) holds the gear code in bits 2:0 and the source select in bit 3, where 0 picks fast and 1 picks slow. `WARM` (address 2) holds the warm-up period code in bits 1:0.

The warm-up counter counts pulses of the oscillator that is being brought up. Software starts it, polls `warm_busy` until it falls, and only then moves the source select. Gear and source changes are held back until a full system period has finished, so no short pulse reaches the output.

Top module: `clkgear_ctrl`

## Requirements
- R1: After reset the gear is 4, the fast enable is 1, the slow enable is 0, the source is 0 (fast), the warm code is 2, `warm_busy` is 0, and `sys_tick` pulses every 32 `clk` cycles.
- R2: With the fast source selected and enabled, gear code g (0 to 4) gives a `sys_tick` spacing of 2^(g+1) `clk` cycles.
- R3: A write of gear code 5, 6 or 7 leaves the stored gear and the output period unchanged.
- R4: Warm code 1 selects 2^WU_S counts, code 2 selects 2^WU_M counts and code 3 selects 2^WU_L counts. A write of code 0 is stored as 1.
- R5: Writing 1 to `OSC` bit 2 raises `warm_busy` for exactly the selected number of count events. Those events are enabled `fs_tick` pulses while the source is 0, and enabled `clk` cycles while the source is 1.
- R6: A write to `CLK` that asks for the other source is accepted only if that source's enable is 1 and `warm_busy` is 0. Otherwise the source select keeps its value.
- R7: With the slow source selected, `sys_tick` rises on every second `fs_tick` that arrives while the slow enable is 1. While the slow enable is 0, no `sys_tick` occurs.
- R8: A gear or source write shows on the outputs `gear_sel` and `src_sel` at once. The divider uses the new value only from the `sys_tick` that ends the current system period, so that period keeps its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_tick | input | 1 | One-cycle pulse per slow oscillator period |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 OSC, 1 CLK, 2 WARM |
| cfg_wdata | input | 4 | Register write data |
| hi_osc_en | output | 1 | Fast oscillator gate |
| lo_osc_en | output | 1 | Slow oscillator gate |
| src_sel | output | 1 | Stored source select (0 fast, 1 slow) |
| gear_sel | output | 3 | Stored gear code |
| warm_sel | output | 2 | Stored warm-up period code |
| warm_busy | output | 1 | Warm-up counter running |
| sys_tick | output | 1 | System state clock enable |

## Verification
The bench steps through every legal gear code and measures the gap between `sys_tick` pulses. A wrong divide ratio and a missing final halving each show up as a distinct gap. It also writes each reserved gear code, which separates rejection from decoding of the low bits only. Writing a gear right at a `sys_tick` shows whether the old period runs to its end or is cut short. The warm-up length is counted under both counting clocks and under every period code, including the reserved code 0. Switch attempts with the target disabled, switch attempts during warm-up, and gating of the slow enable each exercise a separate guard.

// File: rtl/clkgear_pkg.sv
package clkgear_pkg;

  localparam int GEAR_W = 3;
  localparam int DIV_W  = 4;
  localparam logic [GEAR_W-1:0] GEAR_TOP = 3'd4;

  typedef enum logic [1:0] {
    A_OSC  = 2'd0,
    A_CLK  = 2'd1,
    A_WARM = 2'd2,
    A_NONE = 2'd3
  } cfg_addr_e;

  // gear codes above GEAR_TOP are reserved
  function automatic logic gear_legal(input logic [GEAR_W-1:0] g);
    return g <= GEAR_TOP;
  endfunction

  // divider reload value: 2^g - 1 fast cycles between geared pulses
  function automatic logic [DIV_W-1:0] gear_reload(input logic [GEAR_W-1:0] g);
    return (DIV_W'(1) << g) - DIV_W'(1);
  endfunction

  // exponent of the warm-up length for a period code
  function automatic int unsigned warm_exp(input logic [1:0] code,
                                           input int unsigned e_s,
                                           input int unsigned e_m,
                                           input int unsigned e_l);
    case (code)
      2'd2:    return e_m;
      2'd3:    return e_l;
      default: return e_s;
    endcase
  endfunction

endpackage

// File: rtl/clkgear_warmup.sv
module clkgear_warmup
  import clkgear_pkg::*;
#(
  parameter int unsigned WU_S = 8,
  parameter int unsigned WU_M = 14,
  parameter int unsigned WU_L = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] code,
  input  logic       count_en,
  output logic       busy
);
  localparam int CW = WU_L + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (start)                cnt <= CW'(1) << warm_exp(code, WU_S, WU_M, WU_L);
    else if (count_en && busy)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  p_start_raises_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_busy_ends_on_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(count_en));

endmodule

// File: rtl/clkgear_regs.sv
module clkgear_regs
  import clkgear_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [3:0]        cfg_wdata,
  input  logic              warm_busy,
  output logic              hi_en,
  output logic              lo_en,
  output logic              src_q,
  output logic [GEAR_W-1:0] gear_q,
  output logic [1:0]        warm_code,
  output logic              warm_start
);
  logic wr_osc, wr_clk, wr_warm;
  logic src_req, target_en, src_ok, gear_ok;

  assign wr_osc  = cfg_we && (cfg_addr == A_OSC);
  assign wr_clk  = cfg_we && (cfg_addr == A_CLK);
  assign wr_warm = cfg_we && (cfg_addr == A_WARM);

  assign warm_start = wr_osc && cfg_wdata[2];
  assign src_req    = cfg_wdata[3];
  assign target_en  = src_req ? lo_en : hi_en;
  assign src_ok     = wr_clk && (src_req != src_q) && target_en && !warm_busy;
  assign gear_ok    = wr_clk && gear_legal(cfg_wdata[GEAR_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_en     <= 1'b1;
      lo_en     <= 1'b0;
      src_q     <= 1'b0;
      gear_q    <= GEAR_TOP;
      warm_code <= 2'd2;
    end else begin
      if (wr_osc) begin
        hi_en <= cfg_wdata[0];
        lo_en <= cfg_wdata[1];
      end
      if (src_ok)  src_q  <= src_req;
      if (gear_ok) gear_q <= cfg_wdata[GEAR_W-1:0];
      if (wr_warm) warm_code <= (cfg_wdata[1:0] == 2'd0) ? 2'd1 : cfg_wdata[1:0];
    end
  end

  p_gear_never_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gear_q <= GEAR_TOP);
  p_warm_code_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    warm_code != 2'd0);
  p_switch_guarded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q != $past(src_q)) |->
      (!$past(warm_busy) && (src_q ? $past(lo_en) : $past(hi_en))));

endmodule

// File: rtl/clkgear_divider.sv
module clkgear_divider
  import clkgear_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic              lo_en,
  input  logic              fs_tick,
  input  logic              src_q,
  input  logic [GEAR_W-1:0] gear_q,
  output logic              sys_tick
);
  logic [DIV_W-1:0]  div_cnt;
  logic [GEAR_W-1:0] gear_act;
  logic              src_act;
  logic              phase;
  logic              g_tick;
  logic              s_tick;
  logic              sel_tick;

  assign g_tick   = hi_en && (div_cnt == '0);
  assign s_tick   = lo_en && fs_tick;
  assign sel_tick = src_act ? s_tick : g_tick;
  assign sys_tick = sel_tick && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= gear_reload(GEAR_TOP);
      gear_act <= GEAR_TOP;
      src_act  <= 1'b0;
      phase    <= 1'b0;
    end else if (sys_tick) begin
      // end of a full system period: pick up pending settings
      phase    <= 1'b0;
      gear_act <= gear_q;
      src_act  <= src_q;
      div_cnt  <= gear_reload(gear_q);
    end else begin
      if (sel_tick) phase <= ~phase;
      if (g_tick)     div_cnt <= gear_reload(gear_act);
      else if (hi_en) div_cnt <= div_cnt - 1'b1;
    end
  end

  p_no_adjacent_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |=> !sys_tick);
  p_gear_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gear_act != $past(gear_act)) |-> $past(sys_tick));
  p_src_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_act != $past(src_act)) |-> $past(sys_tick));
  p_slow_tick_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick && src_act) |-> (fs_tick && lo_en));

endmodule

// File: rtl/clkgear_ctrl.sv
module clkgear_ctrl
  import clkgear_pkg::*;
#(
  parameter int unsigned WU_S = 8,
  parameter int unsigned WU_M = 14,
  parameter int unsigned WU_L = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_tick,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [3:0] cfg_wdata,
  output logic       hi_osc_en,
  output logic       lo_osc_en,
  output logic       src_sel,
  output logic [2:0] gear_sel,
  output logic [1:0] warm_sel,
  output logic       warm_busy,
  output logic       sys_tick
);
  logic warm_start;
  logic warm_count_en;

  clkgear_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .warm_busy (warm_busy),
    .hi_en     (hi_osc_en),
    .lo_en     (lo_osc_en),
    .src_q     (src_sel),
    .gear_q    (gear_sel),
    .warm_code (warm_sel),
    .warm_start(warm_start)
  );

  // warm-up counts the oscillator not currently driving the system clock
  assign warm_count_en = src_sel ? hi_osc_en : (lo_osc_en && fs_tick);

  clkgear_warmup #(.WU_S(WU_S), .WU_M(WU_M), .WU_L(WU_L)) u_warm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (warm_start),
    .code    (warm_sel),
    .count_en(warm_count_en),
    .busy    (warm_busy)
  );

  clkgear_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_en   (hi_osc_en),
    .lo_en   (lo_osc_en),
    .fs_tick (fs_tick),
    .src_q   (src_sel),
    .gear_q  (gear_sel),
    .sys_tick(sys_tick)
  );

endmodule

// File: tb/clkgear_ctrl_bench.sv
`timescale 1ns/1ps
module clkgear_ctrl_bench;
  localparam int E_S = 2, E_M = 3, E_L = 4;
  localparam int FS_DIV = 5;

  logic clk = 1'b0, rst_n = 1'b0, fs_tick = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [3:0] cfg_wdata = 4'd0;
  logic hi_osc_en, lo_osc_en, src_sel, warm_busy, sys_tick;
  logic [2:0] gear_sel;
  logic [1:0] warm_sel;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkgear_ctrl #(.WU_S(E_S), .WU_M(E_M), .WU_L(E_L)) u_clkgear_ctrl (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .hi_osc_en(hi_osc_en),
    .lo_osc_en(lo_osc_en), .src_sel(src_sel), .gear_sel(gear_sel),
    .warm_sel(warm_sel), .warm_busy(warm_busy), .sys_tick(sys_tick));

  // slow source: one pulse every FS_DIV fast cycles, moved just after posedge
  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      #1;
      k = (k == FS_DIV-1) ? 0 : k + 1;
      fs_tick = (k == FS_DIV-1);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!sys_tick) @(negedge clk);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sys_tick);
  endtask

  task automatic warm_clk_len(output int n);
    n = 0;
    while (warm_busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int g, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 gear", gear_sel, 4);
    check("R1 hi_en", hi_osc_en, 1);
    check("R1 lo_en", lo_osc_en, 0);
    check("R1 src", src_sel, 0);
    check("R1 warm code", warm_sel, 2);
    check("R1 busy", warm_busy, 0);
    wait_tick(); gap(n);
    check("R1 period", n, 32);

    // R2 every legal gear code
    for (int gc = 0; gc <= 4; gc++) begin
      wr(2'd1, 4'(gc));
      check("R2 readback", gear_sel, gc);
      wait_tick(); gap(n);
      check("R2 period", n, 1 << (gc + 1));
    end

    // R3 reserved gear codes
    for (int gc = 5; gc <= 7; gc++) begin
      wr(2'd1, 4'(gc));
      check("R3 gear kept", gear_sel, 4);
    end
    wait_tick(); gap(n);
    check("R3 period kept", n, 32);

    // R8 write at a tick: old period completes, then new gear
    wait_tick();
    wr(2'd1, 4'd0);
    check("R8 readback", gear_sel, 0);
    g = 1;
    while (!sys_tick) begin @(negedge clk); g++; end
    check("R8 old period kept", g, 32);
    gap(n);
    check("R8 new period", n, 2);

    // R6 switch to disabled slow source rejected
    wr(2'd1, 4'b1000);
    check("R6 disabled target", src_sel, 0);

    // enable both, R4 code 0 stored as 1
    wr(2'd0, 4'b0011);
    wr(2'd2, 4'd0);
    check("R4 code0->1", warm_sel, 1);

    // R6 switch rejected during warm-up
    wr(2'd0, 4'b0111);
    wr(2'd1, 4'b1000);
    check("R6 busy reject", src_sel, 0);
    while (warm_busy) @(negedge clk);

    // R5 warm-up counts slow pulses while on fast source
    wr(2'd0, 4'b0111);
    n = 0;
    while (warm_busy) begin if (fs_tick) n++; @(negedge clk); end
    check("R5 fs count", n, 1 << E_S);

    // R6 accepted switch, R7 slow period
    wr(2'd1, 4'b1100);
    check("R6 accept", src_sel, 1);
    wait_tick(); wait_tick(); gap(n);
    check("R7 slow period", n, 2 * FS_DIV);

    // R4/R5 warm-up on fast clock for each code
    wr(2'd2, 4'd3); check("R4 code3", warm_sel, 3);
    wr(2'd0, 4'b0111); warm_clk_len(n);
    check("R5 len code3", n, 1 << E_L);
    wr(2'd2, 4'd2);
    wr(2'd0, 4'b0111); warm_clk_len(n);
    check("R4 len code2", n, 1 << E_M);
    wr(2'd2, 4'd1);
    wr(2'd0, 4'b0111); warm_clk_len(n);
    check("R4 len code1", n, 1 << E_S);

    // R7 gated slow oscillator gives no ticks
    wr(2'd0, 4'b0001);
    n = 0;
    repeat (60) begin @(negedge clk); if (sys_tick) n++; end
    check("R7 gated", n, 0);
    wr(2'd0, 4'b0011);
    wait_tick(); gap(n);
    check("R7 resumed", n, 2 * FS_DIV);

    // R6 back to disabled fast source rejected
    wr(2'd0, 4'b0010);
    wr(2'd1, 4'b0001);
    check("R6 fast disabled", src_sel, 1);
    check("R3 gear legal write", gear_sel, 1);
    wr(2'd0, 4'b0011);
    wr(2'd1, 4'b0001);
    check("R6 back to fast", src_sel, 0);
    wait_tick(); gap(n);
    check("R8 fast after switch", n, 4);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule